// File: doc/BRIEF.md
# Linked-Descriptor and Circular-Buffer DMA Channel

This block is a one-way DMA channel. It reads 16-bit words from a paged memory and passes the low byte of each word to a byte-wide peripheral, such as a serial transmitter. The host sets the channel up through a small register port. The channel then works with no further host action.

It runs in one of two modes:

- **Descriptor mode.** The channel walks a chain of five-word descriptor blocks in page 0 of memory. Before it loads a block it checks the block's ownership flag. When a block is done it writes status back to the block and follows the next-pointer. A block whose configuration word is all zero ends the chain.
- **Autobuffer mode.** The channel streams one linear region again and again, as a circular buffer. It can raise interrupts at the half-way point and at the end of each pass.

A single interrupt line stays high until the host clears it with a register write.

Top module: `dma_chan`

## Requirements
- R1: A descriptor at head address H occupies words H..H+4 of page 0: configuration, start page, start address, word count, next-descriptor pointer. The channel reads `count` words from memory at (page, address), (page, address+1), and so on. For each word it delivers bits [7:0] to the peripheral, in address order.
- R2: Bit 15 of the configuration word is the ownership flag. If that bit reads 0, the channel loads no further descriptor words and delivers no data.
- R3: After reading ownership as 0, the channel re-reads the configuration word only when the host writes to the descriptor-ready register (offset 2). A later change of the memory word alone has no effect.
- R4: When the last word of a descriptor has been delivered, the channel writes the configuration word back to the head address with bit 15 cleared and bit 3 set. It then fetches the descriptor at the next pointer.
- R5: A configuration word that reads as all zero clears the enable bit (bit 0 of the control register, offset 0), and the channel stops.
- R6: In descriptor mode, the interrupt is raised after a descriptor's write-back only if bit 2 of that descriptor's configuration word is set.
- R7: With control bit 4 (autobuffer) and bit 0 set, the channel streams words from the start address for `count` words (offset 5). It then reloads the start address (offset 4) and the count, and repeats.
- R8: In autobuffer mode with control bit 2 set, the interrupt is raised after transfer number count − floor(count/2) of each pass, and again after transfer number `count`. For example, 11 words raise it after transfers 6 and 11.
- R9: Clearing control bit 0 aborts the channel. No further peripheral acknowledges or memory requests occur. Re-enabling in autobuffer mode restarts at the start address.
- R10: Writing 0x0001 to the interrupt register (offset 6) clears a pending interrupt. Other values leave it set. Reading offset 6 returns the pending flag in bit 0.
- R11: The page, address and count registers (offsets 3, 4 and 5) ignore host writes unless control bit 4 is set.
- R12: Each acknowledge pulse lasts one cycle, answers a request that was high on the previous clock, and carries the data byte.
- R13: After reset the interrupt, acknowledge and memory request are low, and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset for read and write |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data, one cycle after the address |
| mem_req | output | 1 | Memory access request, held until ready |
| mem_we | output | 1 | Access is a write (status write-back) |
| mem_page | output | PAGE_W | Memory page (0 for descriptor accesses) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory completes the access this cycle |
| per_req | input | 1 | Peripheral can accept a byte |
| per_ack | output | 1 | One-cycle pulse: byte delivered |
| per_data | output | PER_W | Byte delivered with the acknowledge |
| irq | output | 1 | Pending interrupt |

## Verification

**Autobuffer runs.** Each run covers two full passes and is repeated for counts of 11, 10, 3, 2 and 1. These counts separate the rounding of the half-way point for odd and even lengths. With counts 1 and 2 the two interrupt points coincide or sit next to each other.

**Descriptor chain.** A two-block chain that ends in a zero block shows three things: the interrupt is gated per block, write-back goes to the right head word, and the page field is passed through.

**Ownership stall.** An unowned block is held while memory is changed and again after a ready-register write. This separates "re-poll on strobe" from "re-poll on memory change".

**Abort.** An abort in the middle of a pass is followed by a restart. This shows that the channel stops and then resumes at the start address.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned WORD_W = 16;

  // register offsets
  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_NEXT  = 3'd1;
  localparam logic [2:0] OFS_READY = 3'd2;
  localparam logic [2:0] OFS_PAGE  = 3'd3;
  localparam logic [2:0] OFS_ADDR  = 3'd4;
  localparam logic [2:0] OFS_COUNT = 3'd5;
  localparam logic [2:0] OFS_IRQ   = 3'd6;

  // configuration bit positions
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_IE   = 2;
  localparam int unsigned BIT_DONE = 3;
  localparam int unsigned BIT_AUTO = 4;
  localparam int unsigned BIT_OWN  = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_WAIT,
    ST_LOAD,
    ST_FETCH,
    ST_PER,
    ST_WB
  } dma_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              clr_en,
  input  logic              irq_set,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [15:0]       ctrl,
  output logic              irq,
  output logic              wr_next,
  output logic              wr_ready,
  output logic              wr_page,
  output logic              wr_addr,
  output logic              wr_cnt
);
  logic auto_sel;

  assign auto_sel = ctrl[BIT_AUTO];
  assign wr_next  = host_wr && host_addr == OFS_NEXT;
  assign wr_ready = host_wr && host_addr == OFS_READY;
  // start registers accept host writes only in circular mode
  assign wr_page  = host_wr && host_addr == OFS_PAGE  && auto_sel;
  assign wr_addr  = host_wr && host_addr == OFS_ADDR  && auto_sel;
  assign wr_cnt   = host_wr && host_addr == OFS_COUNT && auto_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (host_wr && host_addr == OFS_CTRL) begin
      ctrl <= host_wdata;
    end else if (clr_en) begin
      ctrl[BIT_EN] <= 1'b0;
    end
  end

  // a set from the engine wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (irq_set) begin
      irq <= 1'b1;
    end else if (host_wr && host_addr == OFS_IRQ && host_wdata == 16'h0001) begin
      irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      unique case (host_addr)
        OFS_CTRL:  host_rdata <= ctrl;
        OFS_NEXT:  host_rdata <= 16'(ptr_i);
        OFS_PAGE:  host_rdata <= 16'(page_i);
        OFS_ADDR:  host_rdata <= 16'(addr_i);
        OFS_COUNT: host_rdata <= 16'(cnt_i);
        OFS_IRQ:   host_rdata <= {15'd0, irq};
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              auto_mode,
  input  logic              auto_ie,
  input  logic              wr_next,
  input  logic              wr_ready,
  input  logic              wr_page,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [ADDR_W-1:0] next_wdata,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_page,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ready,
  input  logic              per_req,
  output logic              per_ack,
  output logic [PER_W-1:0]  per_data,
  output logic              clr_en,
  output logic              irq_set,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [2:0] LAST_IDX = 3'd4;

  dma_state_t        state;
  logic [ADDR_W-1:0] head;
  logic [ADDR_W-1:0] nxt;
  logic [15:0]       dcfg;
  logic [PAGE_W-1:0] page_r;
  logic [ADDR_W-1:0] saddr;
  logic [CNT_W-1:0]  scnt;
  logic [ADDR_W-1:0] caddr;
  logic [CNT_W-1:0]  left;
  logic [CNT_W-1:0]  done_n;
  logic [2:0]        idx;
  logic [PER_W-1:0]  word;
  logic [CNT_W-1:0]  half_pt;
  logic              last_xfer;
  logic              take;

  assign ptr_o  = head;
  assign page_o = page_r;
  assign addr_o = saddr;
  assign cnt_o  = scnt;

  // half-way transfer number: count minus floor(count/2)
  assign half_pt   = scnt - (scnt >> 1);
  assign last_xfer = left == CNT_W'(1);
  assign take      = en && state == ST_PER && per_req;

  always_comb begin
    mem_req   = en && (state == ST_CFG || state == ST_LOAD ||
                       state == ST_FETCH || state == ST_WB);
    mem_we    = state == ST_WB;
    mem_page  = (state == ST_FETCH) ? page_r : '0;
    mem_wdata = dcfg;
    mem_wdata[BIT_OWN]  = 1'b0;
    mem_wdata[BIT_DONE] = 1'b1;
    unique case (state)
      ST_LOAD:  mem_addr = head + ADDR_W'(idx);
      ST_FETCH: mem_addr = caddr;
      default:  mem_addr = head;
    endcase
  end

  always_comb begin
    clr_en  = en && state == ST_CFG && mem_ready && mem_rdata == '0;
    irq_set = (take && auto_mode && auto_ie &&
               ((done_n + CNT_W'(1)) == half_pt || last_xfer)) ||
              (en && state == ST_WB && mem_ready && dcfg[BIT_IE]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      head     <= '0;
      nxt      <= '0;
      dcfg     <= '0;
      page_r   <= '0;
      saddr    <= '0;
      scnt     <= '0;
      caddr    <= '0;
      left     <= '0;
      done_n   <= '0;
      idx      <= '0;
      word     <= '0;
      per_ack  <= 1'b0;
      per_data <= '0;
    end else begin
      per_ack <= 1'b0;
      if (wr_next) head   <= next_wdata;
      if (wr_page) page_r <= page_wdata;
      if (wr_addr) saddr  <= addr_wdata;
      if (wr_cnt)  scnt   <= cnt_wdata;
      if (!en) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (!auto_mode) begin
              state <= ST_CFG;
            end else if (scnt != '0) begin
              caddr  <= saddr;
              left   <= scnt;
              done_n <= '0;
              state  <= ST_FETCH;
            end
          end
          ST_CFG: begin
            if (mem_ready) begin
              if (mem_rdata == '0) begin
                state <= ST_IDLE;
              end else if (!mem_rdata[BIT_OWN]) begin
                state <= ST_WAIT;
              end else begin
                dcfg  <= mem_rdata;
                idx   <= 3'd1;
                state <= ST_LOAD;
              end
            end
          end
          ST_WAIT: begin
            if (wr_ready) state <= ST_CFG;
          end
          ST_LOAD: begin
            if (mem_ready) begin
              unique case (idx)
                3'd1:    page_r <= mem_rdata[PAGE_W-1:0];
                3'd2:    saddr  <= mem_rdata[ADDR_W-1:0];
                3'd3:    scnt   <= mem_rdata[CNT_W-1:0];
                default: nxt    <= mem_rdata[ADDR_W-1:0];
              endcase
              idx <= idx + 3'd1;
              if (idx == LAST_IDX) begin
                caddr  <= saddr;
                left   <= scnt;
                done_n <= '0;
                state  <= (scnt == '0) ? ST_WB : ST_FETCH;
              end
            end
          end
          ST_FETCH: begin
            if (mem_ready) begin
              word  <= mem_rdata[PER_W-1:0];
              state <= ST_PER;
            end
          end
          ST_PER: begin
            if (per_req) begin
              per_ack  <= 1'b1;
              per_data <= word;
              if (last_xfer) begin
                if (auto_mode) begin
                  caddr  <= saddr;
                  left   <= scnt;
                  done_n <= '0;
                  state  <= ST_FETCH;
                end else begin
                  state <= ST_WB;
                end
              end else begin
                caddr  <= caddr + ADDR_W'(1);
                left   <= left - CNT_W'(1);
                done_n <= done_n + CNT_W'(1);
                state  <= ST_FETCH;
              end
            end
          end
          ST_WB: begin
            if (mem_ready) begin
              head  <= nxt;
              state <= ST_CFG;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_page,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ready,
  input  logic              per_req,
  output logic              per_ack,
  output logic [PER_W-1:0]  per_data,
  output logic              irq
);
  logic [15:0]       ctrl;
  logic              clr_en;
  logic              irq_set;
  logic              wr_next, wr_ready, wr_page, wr_addr, wr_cnt;
  logic [ADDR_W-1:0] ptr_v;
  logic [PAGE_W-1:0] page_v;
  logic [ADDR_W-1:0] addr_v;
  logic [CNT_W-1:0]  cnt_v;

  dma_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .clr_en(clr_en), .irq_set(irq_set),
    .ptr_i(ptr_v), .page_i(page_v), .addr_i(addr_v), .cnt_i(cnt_v),
    .ctrl(ctrl), .irq(irq),
    .wr_next(wr_next), .wr_ready(wr_ready), .wr_page(wr_page),
    .wr_addr(wr_addr), .wr_cnt(wr_cnt)
  );

  dma_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .PER_W(PER_W)) i_seq (
    .clk(clk), .rst(rst),
    .en(ctrl[BIT_EN]), .auto_mode(ctrl[BIT_AUTO]), .auto_ie(ctrl[BIT_IE]),
    .wr_next(wr_next), .wr_ready(wr_ready), .wr_page(wr_page),
    .wr_addr(wr_addr), .wr_cnt(wr_cnt),
    .next_wdata(host_wdata[ADDR_W-1:0]), .page_wdata(host_wdata[PAGE_W-1:0]),
    .addr_wdata(host_wdata[ADDR_W-1:0]), .cnt_wdata(host_wdata[CNT_W-1:0]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_page(mem_page),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .per_req(per_req), .per_ack(per_ack), .per_data(per_data),
    .clr_en(clr_en), .irq_set(irq_set),
    .ptr_o(ptr_v), .page_o(page_v), .addr_o(addr_v), .cnt_o(cnt_v)
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic [2:0]        host_addr,
  input logic [15:0]       host_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              mem_ready,
  input logic              per_req,
  input logic              per_ack,
  input logic              irq,
  input logic              irq_set,
  input logic              ctrl_en,
  input logic              ctrl_auto,
  input logic [CNT_W-1:0]  cnt_start
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    per_ack |=> !per_ack); // R12
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> $past(per_req)); // R12
  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> $past(ctrl_en)); // R9
  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (!mem_wdata[15] && mem_wdata[3])); // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd6 && host_wdata == 16'h0001 && !irq_set) |=> !irq); // R10
  AST_RO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd5 && !ctrl_auto && !mem_req) |=> $stable(cnt_start)); // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready && ctrl_en && !host_wr) |=> (mem_req && $stable(mem_addr))); // R1
endmodule

bind dma_chan dma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst),
  .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .per_req(per_req), .per_ack(per_ack), .irq(irq),
  .irq_set(irq_set), .ctrl_en(ctrl[0]), .ctrl_auto(ctrl[4]),
  .cnt_start(cnt_v)
);

// File: tb/test_dma_chan.sv
module test_dma_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [7:0]  mem_page;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        per_req = 1'b0;
  logic        per_ack;
  logic [7:0]  per_data;
  logic        irq;

  logic [15:0] mem [256];
  int checks = 0;
  int errors = 0;
  int ack_cnt = 0;
  int rd60 = 0;
  logic [7:0] seen_page = 8'hFF;
  bit finished = 1'b0;

  // start, count, expected half-way transfer number
  localparam logic [23:0] VECS [5] = '{
    {8'h80, 8'd11, 8'd6},
    {8'h90, 8'd10, 8'd5},
    {8'hA0, 8'd1,  8'd1},
    {8'hA8, 8'd3,  8'd2},
    {8'hB0, 8'd2,  8'd1}
  };

  always #5 clk = ~clk;

  dma_chan i_dma_chan (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_page(mem_page),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .per_req(per_req), .per_ack(per_ack), .per_data(per_data),
    .irq(irq)
  );

  assign mem_ready = mem_req;
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:0]] = mem_wdata;
  end

  always @(negedge clk) begin
    if (per_ack) ack_cnt++;
    if (mem_req && !mem_we && mem_addr == 16'h0060) rd60++;
    if (mem_req && !mem_we && mem_addr == 16'h0050) seen_page = mem_page;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic take(input string req, output logic [7:0] d);
    bit got = 1'b0;
    @(negedge clk);
    per_req = 1'b1;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (per_ack) begin
        d = per_data;
        got = 1'b1;
        break;
      end
    end
    per_req = 1'b0;
    if (!got) begin
      d = 8'h00;
      check(req, 0, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  b;
    int a0;
    for (int a = 0; a < 256; a++) mem[a] = 16'hA500 | 16'(a);
    // descriptor chain: 0x10 -> 0x20 -> 0x30 (zero)
    mem[8'h10] = 16'h8001; mem[8'h11] = 16'h0003; mem[8'h12] = 16'h0040;
    mem[8'h13] = 16'h0003; mem[8'h14] = 16'h0020;
    mem[8'h20] = 16'h8005; mem[8'h21] = 16'h0007; mem[8'h22] = 16'h0050;
    mem[8'h23] = 16'h0002; mem[8'h24] = 16'h0030;
    mem[8'h30] = 16'h0000;
    // unowned descriptor at 0x60
    mem[8'h60] = 16'h0001; mem[8'h61] = 16'h0002; mem[8'h62] = 16'h0070;
    mem[8'h63] = 16'h0001; mem[8'h64] = 16'h0030;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R13 reset state
    check("R13 irq", int'(irq), 0);
    check("R13 ack", int'(per_ack), 0);
    check("R13 mem_req", int'(mem_req), 0);
    rd(3'd0, r);
    check("R13 ctrl", int'(r), 0);

    // R11 count write ignored without autobuffer
    wr(3'd5, 16'd5);
    rd(3'd5, r);
    check("R11 count read-only", int'(r), 0);

    // R7/R8/R10 autobuffer table
    for (int v = 0; v < 5; v++) begin
      int st, cnt, hp;
      st  = int'(VECS[v][23:16]);
      cnt = int'(VECS[v][15:8]);
      hp  = int'(VECS[v][7:0]);
      wr(3'd0, 16'h0000);
      wr(3'd0, 16'h0010);
      wr(3'd3, 16'h0000);
      wr(3'd4, 16'(st));
      wr(3'd5, 16'(cnt));
      rd(3'd5, r);
      check("R11 count writable in autobuffer", int'(r), cnt);
      wr(3'd0, 16'h0015);
      for (int k = 0; k < 2 * cnt; k++) begin
        int pos;
        pos = (k % cnt) + 1;
        take("R7 byte arrives", b);
        check("R7 circular data", int'(b), (st + (k % cnt)) & 8'hFF);
        check("R8 irq point", int'(irq), (pos == hp || pos == cnt) ? 1 : 0);
        if (irq) begin
          if (v == 0 && k == hp - 1) begin
            wr(3'd6, 16'h0002);
            check("R10 other value keeps irq", int'(irq), 1);
          end
          wr(3'd6, 16'h0001);
          check("R10 irq cleared", int'(irq), 0);
        end
      end
    end
    wr(3'd0, 16'h0000);

    // R1/R4/R5/R6 descriptor chain
    wr(3'd1, 16'h0010);
    wr(3'd0, 16'h0001);
    for (int k = 0; k < 3; k++) begin
      take("R1 byte arrives", b);
      check("R1 desc1 data", int'(b), 8'h40 + k);
    end
    repeat (10) @(negedge clk);
    check("R6 no irq without enable bit", int'(irq), 0);
    for (int k = 0; k < 2; k++) begin
      take("R1 byte arrives", b);
      check("R4 follows next pointer", int'(b), 8'h50 + k);
    end
    repeat (20) @(negedge clk);
    check("R6 irq after flagged descriptor", int'(irq), 1);
    check("R4 writeback desc1", int'(mem[8'h10]), 16'h0009);
    check("R4 writeback desc2", int'(mem[8'h20]), 16'h000D);
    check("R1 page passed through", int'(seen_page), 8'h07);
    rd(3'd0, r);
    check("R5 zero config clears enable", int'(r), 0);
    rd(3'd3, r);
    check("R1 page register loaded", int'(r), 7);
    wr(3'd6, 16'h0001);

    // R2/R3 ownership wait
    wr(3'd1, 16'h0060);
    wr(3'd0, 16'h0001);
    a0 = ack_cnt;
    per_req = 1'b1;
    repeat (40) @(negedge clk);
    check("R2 unowned gives no data", ack_cnt - a0, 0);
    check("R2 single config read", rd60, 1);
    mem[8'h60] = 16'h8001;
    repeat (40) @(negedge clk);
    per_req = 1'b0;
    check("R3 no re-read on memory change", rd60, 1);
    check("R3 still no data", ack_cnt - a0, 0);
    wr(3'd2, 16'h0001);
    take("R3 byte after ready write", b);
    check("R3 data after ready write", int'(b), 8'h70);
    check("R3 config re-read once", rd60, 2);
    repeat (20) @(negedge clk);
    check("R4 writeback owned block", int'(mem[8'h60]), 16'h0009);

    // R9 abort and restart
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0010);
    wr(3'd4, 16'h00C0);
    wr(3'd5, 16'h0004);
    wr(3'd0, 16'h0011);
    take("R9 byte", b);
    check("R9 first byte", int'(b), 8'hC0);
    take("R9 byte", b);
    check("R9 second byte", int'(b), 8'hC1);
    wr(3'd0, 16'h0010);
    repeat (3) @(negedge clk);
    a0 = ack_cnt;
    per_req = 1'b1;
    repeat (30) @(negedge clk);
    check("R9 no ack after abort", ack_cnt - a0, 0);
    check("R9 no memory request after abort", int'(mem_req), 0);
    per_req = 1'b0;
    wr(3'd0, 16'h0011);
    take("R9 byte", b);
    check("R9 restart at start", int'(b), 8'hC0);
    wr(3'd0, 16'h0000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule